// File: doc/BRIEF.md
# Transmit Descriptor Poll Engine

This block is the transmit half of a descriptor-driven network DMA engine. Software places descriptors in memory, each four 32-bit words: a status word (hardware-ownership flag in bit 31), a control word (flags plus byte count), a buffer byte address, and a spare word. Software hands a descriptor to hardware by setting its ownership flag and then writes the poll-demand register. The engine reads the descriptor through a simple memory port. If hardware owns it, the engine streams the buffer out as bytes on a ready/valid interface. It then writes the completion status back, which returns the descriptor to software. It carries on with the next descriptor until it meets one it does not own.

A setup-type descriptor is never sent on the wire. The engine reads the first words of its buffer and loads the station address register from their low halves. A small register port holds a transmit-enable bit, the ring base, the poll-demand strobe and a process-state field.

Top module: `txd_poll_engine`

## Requirements
- R1: After reset tx_valid is low, mem_req is low, stn_addr is zero and the process-state field reads 0.
- R2: A poll-demand write (offset 0x4) with transmit enabled reads the status word at the current descriptor. If bit 31 of that word is clear, no byte is sent, nothing is written back, the state field reads 6 (suspended), and the next poll re-reads the same descriptor.
- R3: A poll-demand write while the enable bit (bit 13 of the control register at offset 0x0) is clear is ignored: no memory request, and the state field stays 0.
- R4: A descriptor with control bit 29 (first) and bit 30 (last) set, bit 27 clear and a nonzero length in bits 10:0 sends exactly that many bytes from the buffer, in ascending byte address order. Byte lane n of a memory word holds address offset n, and the buffer may start at any byte. tx_last is high on the final byte only.
- R5: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data and tx_last hold their values.
- R6: A successfully sent frame gets status word 0x00000000 written back. Every write-back clears bit 31.
- R7: A normal descriptor without both bit 29 and bit 30 set, or with zero length, sends no byte and gets status 0x00008000 (bit 15 set, error summary).
- R8: A setup descriptor (control bit 27) with length 192 sends no byte. It sets stn_addr to {w2[15:0], w1[15:0], w0[15:0]}, where w0..w2 are the first three buffer words, and gets status 0x7FFFFFFF.
- R9: A setup descriptor with a length other than 192 gets status 0x00008000 and leaves stn_addr unchanged.
- R10: After a completion the engine moves to the descriptor 16 bytes further on. If control bit 25 (end of ring) is set, it moves to the ring base (offset 0x8) instead. One poll processes every consecutive owned descriptor.
- R11: Setting the enable bit from 0 to 1 loads the descriptor pointer from the ring base. Clearing it during a frame lets that frame complete, after which the engine stops (state field 0) without reading the next descriptor.
- R12: Bits 22:20 of the status register (offset 0xC) give the process state: 0 stopped, 1 fetching a descriptor, 2 sending, 3 absorbing setup data, 5 writing back, 6 suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_last | output | 1 | Final byte of the frame |
| stn_addr | output | 16*PIECES | Station address register |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, an 11-bit length field and three 16-bit address pieces. It uses a four-entry descriptor ring and a 1 KB memory model. Frame lengths 1 to 9 are swept against all four buffer byte offsets, so every lane-start, word-refill and end-of-word pattern occurs, while the ring wraps nine times. A tx_ready pattern that throttles the stream, plus a long stall with a mid-frame stop, exercise the handshake and the shutdown path.

// File: rtl/txd_pkg.sv
package txd_pkg;

   // Descriptor bit positions; software and engine must agree on these.
   localparam int OWN_BIT   = 31;
   localparam int LAST_BIT  = 30;
   localparam int FIRST_BIT = 29;
   localparam int SETUP_BIT = 27;
   localparam int WRAP_BIT  = 25;
   localparam int START_BIT = 13;
   localparam int PSTATE_LO = 20;

   // Register byte offsets.
   localparam int OFS_CTRL = 4'h0;
   localparam int OFS_POLL = 4'h4;
   localparam int OFS_BASE = 4'h8;
   localparam int OFS_STAT = 4'hC;

   // Completion words.
   localparam logic [31:0] DONE_OK    = 32'h0000_0000;
   localparam logic [31:0] DONE_ERR   = 32'h0000_8000;
   localparam logic [31:0] DONE_SETUP = 32'h7FFF_FFFF;

   // Process-state codes reported to software.
   localparam logic [2:0] PS_STOPPED = 3'd0;
   localparam logic [2:0] PS_FETCH   = 3'd1;
   localparam logic [2:0] PS_SEND    = 3'd2;
   localparam logic [2:0] PS_SETUP   = 3'd3;
   localparam logic [2:0] PS_CLOSE   = 3'd5;
   localparam logic [2:0] PS_SUSPEND = 3'd6;

   typedef enum logic [3:0] {
      S_IDLE, S_RD_STAT, S_RD_CTRL, S_RD_BUF, S_DECIDE,
      S_SU_RD, S_SU_CAP, S_FILL, S_LOAD, S_OUT, S_CLOSE
   } seq_state_e;

endpackage

// File: rtl/txd_csr.sv
module txd_csr
   import txd_pkg::*;
#(
   parameter int AW     = 32,
   parameter int REG_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [2:0]        proc_state,
   output logic              run,
   output logic [AW-1:0]     base,
   output logic              poll,
   output logic              start_rise
);

   logic [31:0] ctrl_q;
   logic [31:0] base_q;
   logic        wr_ctrl, wr_base;

   assign wr_ctrl    = reg_wr && (reg_addr == REG_AW'(OFS_CTRL));
   assign wr_base    = reg_wr && (reg_addr == REG_AW'(OFS_BASE));
   assign poll       = reg_wr && (reg_addr == REG_AW'(OFS_POLL));
   assign run        = ctrl_q[START_BIT];
   assign start_rise = wr_ctrl && reg_wdata[START_BIT] && !ctrl_q[START_BIT];
   assign base       = {base_q[AW-1:4], 4'b0000};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         base_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata;
         if (wr_base) base_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(OFS_CTRL))      reg_rdata = ctrl_q;
      else if (reg_addr == REG_AW'(OFS_BASE)) reg_rdata = base_q;
      else if (reg_addr == REG_AW'(OFS_STAT)) reg_rdata[PSTATE_LO +: 3] = proc_state;
   end

   // R11: a rising enable edge is only reported when enable was clear
   p_rise_from_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      start_rise |=> run)
      else $error("enable rise did not set run");

endmodule

// File: rtl/txd_stn.sv
module txd_stn #(
   parameter int PIECES = 3,
   localparam int IW    = $clog2(PIECES),
   localparam int SW    = 16 * PIECES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic [IW-1:0] cap_idx,
   input  logic [31:0]   cap_word,
   output logic [SW-1:0] stn_addr
);

   logic [SW-1:0] assembled;
   logic [SW-1:0] stn_q;
   logic          commit;

   assign commit = cap_en && (cap_idx == IW'(PIECES - 1));

   for (genvar i = 0; i < PIECES; i++) begin : g_piece
      if (i < PIECES - 1) begin : g_stage
         logic [15:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 stage_q <= '0;
            else if (cap_en && cap_idx == IW'(i))       stage_q <= cap_word[15:0];
         end
         assign assembled[16*i +: 16] = stage_q;
      end else begin : g_tail
         assign assembled[16*i +: 16] = cap_word[15:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stn_q <= '0;
      else if (commit) stn_q <= assembled;
   end

   assign stn_addr = stn_q;

   // R8/R9: the address only moves after the final piece of a setup buffer
   p_stn_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stn_q) |-> $past(cap_en) && $past(cap_idx) == IW'(PIECES - 1))
      else $error("station address changed outside a setup commit");

endmodule

// File: rtl/txd_seq.sv
module txd_seq
   import txd_pkg::*;
#(
   parameter int AW          = 32,
   parameter int LEN_W       = 11,
   parameter int SETUP_LEN   = 192,
   parameter int PIECES      = 3,
   parameter int DESC_STRIDE = 16,
   localparam int IW         = $clog2(PIECES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          poll,
   input  logic          start_rise,
   input  logic [AW-1:0] base,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   output logic          tx_last,
   input  logic          tx_ready,
   output logic          cap_en,
   output logic [IW-1:0] cap_idx,
   output logic [2:0]    proc_state
);

   seq_state_e        state_q, nxt;
   logic [AW-1:0]     desc_q, bptr_q;
   logic [LEN_W-1:0]  len_q, rem_q;
   logic              c_first, c_last, c_setup, c_wrap;
   logic [31:0]       word_q, wb_q;
   logic [IW-1:0]     su_q;
   logic              su_end, frame_ok;

   function automatic logic [AW-1:0] walign(input logic [AW-1:0] a);
      return {a[AW-1:2], 2'b00};
   endfunction

   assign su_end   = (su_q == IW'(PIECES - 1));
   assign frame_ok = c_first && c_last && (len_q != '0);

   always_comb begin
      nxt       = state_q;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = desc_q;
      mem_wdata = wb_q;
      cap_en    = 1'b0;
      unique case (state_q)
         S_IDLE:    if (run && poll) nxt = S_RD_STAT;
         S_RD_STAT: begin
            mem_req = 1'b1;
            nxt     = S_RD_CTRL;
         end
         S_RD_CTRL: begin
            if (mem_rdata[OWN_BIT]) begin
               mem_req  = 1'b1;
               mem_addr = desc_q + AW'(4);
               nxt      = S_RD_BUF;
            end else begin
               nxt = S_IDLE;
            end
         end
         S_RD_BUF: begin
            mem_req  = 1'b1;
            mem_addr = desc_q + AW'(8);
            nxt      = S_DECIDE;
         end
         S_DECIDE: begin
            if (c_setup) nxt = (len_q == LEN_W'(SETUP_LEN)) ? S_SU_RD : S_CLOSE;
            else         nxt = frame_ok ? S_FILL : S_CLOSE;
         end
         S_SU_RD: begin
            mem_req  = 1'b1;
            mem_addr = walign(bptr_q);
            nxt      = S_SU_CAP;
         end
         S_SU_CAP: begin
            cap_en = 1'b1;
            if (su_end) begin
               nxt = S_CLOSE;
            end else begin
               mem_req  = 1'b1;
               mem_addr = walign(bptr_q);
            end
         end
         S_FILL: begin
            mem_req  = 1'b1;
            mem_addr = walign(bptr_q);
            nxt      = S_LOAD;
         end
         S_LOAD: nxt = S_OUT;
         S_OUT: begin
            if (tx_ready) begin
               if (rem_q == LEN_W'(1))       nxt = S_CLOSE;
               else if (bptr_q[1:0] == 2'b11) nxt = S_FILL;
            end
         end
         S_CLOSE: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            nxt     = run ? S_RD_STAT : S_IDLE;
         end
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         desc_q  <= '0;
         bptr_q  <= '0;
         len_q   <= '0;
         rem_q   <= '0;
         c_first <= 1'b0;
         c_last  <= 1'b0;
         c_setup <= 1'b0;
         c_wrap  <= 1'b0;
         word_q  <= '0;
         wb_q    <= '0;
         su_q    <= '0;
      end else begin
         state_q <= nxt;
         unique case (state_q)
            S_IDLE: if (start_rise) desc_q <= base;
            S_RD_BUF: begin
               len_q   <= mem_rdata[LEN_W-1:0];
               c_first <= mem_rdata[FIRST_BIT];
               c_last  <= mem_rdata[LAST_BIT];
               c_setup <= mem_rdata[SETUP_BIT];
               c_wrap  <= mem_rdata[WRAP_BIT];
            end
            S_DECIDE: begin
               bptr_q <= mem_rdata[AW-1:0];
               rem_q  <= len_q;
               su_q   <= '0;
               wb_q   <= DONE_ERR;
            end
            S_SU_RD: bptr_q <= bptr_q + AW'(4);
            S_SU_CAP: begin
               if (su_end) begin
                  wb_q <= DONE_SETUP;
               end else begin
                  bptr_q <= bptr_q + AW'(4);
                  su_q   <= su_q + IW'(1);
               end
            end
            S_LOAD: word_q <= mem_rdata;
            S_OUT: begin
               if (tx_ready) begin
                  bptr_q <= bptr_q + AW'(1);
                  rem_q  <= rem_q - LEN_W'(1);
                  if (rem_q == LEN_W'(1)) wb_q <= DONE_OK;
               end
            end
            S_CLOSE: desc_q <= c_wrap ? base : desc_q + AW'(DESC_STRIDE);
            default: ;
         endcase
      end
   end

   assign cap_idx  = su_q;
   assign tx_valid = (state_q == S_OUT);
   assign tx_last  = (rem_q == LEN_W'(1));

   always_comb begin
      unique case (bptr_q[1:0])
         2'd0:    tx_data = word_q[7:0];
         2'd1:    tx_data = word_q[15:8];
         2'd2:    tx_data = word_q[23:16];
         default: tx_data = word_q[31:24];
      endcase
   end

   always_comb begin
      unique case (state_q)
         S_IDLE:                                 proc_state = run ? PS_SUSPEND : PS_STOPPED;
         S_RD_STAT, S_RD_CTRL, S_RD_BUF, S_DECIDE: proc_state = PS_FETCH;
         S_SU_RD, S_SU_CAP:                      proc_state = PS_SETUP;
         S_FILL, S_LOAD, S_OUT:                  proc_state = PS_SEND;
         default:                                proc_state = PS_CLOSE;
      endcase
   end

   // R5: an offered byte is held until it is taken
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last))
      else $error("byte changed while stalled");

   // R4: the stream drops valid right after the last byte is taken
   p_last_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && tx_last |=> !tx_valid)
      else $error("valid stayed high after last byte");

   // R6: every write-back hands the descriptor back to software
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !mem_wdata[OWN_BIT])
      else $error("write-back kept ownership");

   // R2: an unowned descriptor sends the engine idle with no further access
   p_unowned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == S_RD_CTRL && !mem_rdata[OWN_BIT] |=> !mem_req && !tx_valid)
      else $error("activity after unowned descriptor");

   // R3: a stopped engine makes no memory access
   p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == S_IDLE && !run |=> !mem_req)
      else $error("memory access while stopped");

   // R4: all memory accesses are word aligned
   p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[1:0] == 2'b00)
      else $error("unaligned memory access");

endmodule

// File: rtl/txd_poll_engine.sv
module txd_poll_engine
   import txd_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LEN_W     = 11,
   parameter int SETUP_LEN = 192,
   parameter int PIECES    = 3,
   localparam int IW       = $clog2(PIECES),
   localparam int SW       = 16 * PIECES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [3:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   input  logic          tx_ready,
   output logic          tx_last,
   output logic [SW-1:0] stn_addr
);

   if (AW < 8 || AW > 32) begin : g_bad_aw
      $error("AW must lie in 8..32");
   end
   if (LEN_W < 8 || LEN_W > 25) begin : g_bad_len
      $error("LEN_W must lie in 8..25 to stay clear of the flag bits");
   end
   if (PIECES < 2 || 4 * PIECES > SETUP_LEN) begin : g_bad_pieces
      $error("PIECES must be at least 2 and fit in the setup buffer");
   end
   if (SETUP_LEN >= (1 << LEN_W)) begin : g_bad_setup
      $error("SETUP_LEN does not fit the length field");
   end

   logic          run, poll, start_rise, cap_en;
   logic [AW-1:0] base;
   logic [IW-1:0] cap_idx;
   logic [2:0]    proc_state;

   txd_csr #(.AW(AW), .REG_AW(4)) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .proc_state (proc_state),
      .run        (run),
      .base       (base),
      .poll       (poll),
      .start_rise (start_rise)
   );

   txd_seq #(
      .AW(AW), .LEN_W(LEN_W), .SETUP_LEN(SETUP_LEN), .PIECES(PIECES), .DESC_STRIDE(16)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .poll       (poll),
      .start_rise (start_rise),
      .base       (base),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .tx_last    (tx_last),
      .tx_ready   (tx_ready),
      .cap_en     (cap_en),
      .cap_idx    (cap_idx),
      .proc_state (proc_state)
   );

   txd_stn #(.PIECES(PIECES)) u_stn (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_idx  (cap_idx),
      .cap_word (mem_rdata),
      .stn_addr (stn_addr)
   );

endmodule

// File: tb/tb_txd_poll_engine.sv
module tb_txd_poll_engine;

   localparam int CLK_P = 10;
   localparam logic [31:0] OWN  = 32'h8000_0000;
   localparam logic [31:0] LAST = 32'h4000_0000;
   localparam logic [31:0] FRST = 32'h2000_0000;
   localparam logic [31:0] SETB = 32'h0800_0000;
   localparam logic [31:0] WRAP = 32'h0200_0000;
   localparam int RING_BASE = 32'h40;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_wr = 0;
   logic [3:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = 0;
   logic        tx_valid, tx_last;
   logic [7:0]  tx_data;
   logic        tx_ready = 0;
   logic [47:0] stn_addr;

   logic [31:0] mem [0:255];
   logic [7:0]  got_b [$];
   logic        got_l [$];
   int          n_chk = 0, n_err = 0, cyc = 0, req_cnt = 0, exp_idx = 0;
   bit          hold = 1, ended = 0;

   txd_poll_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_ready(tx_ready), .tx_last(tx_last), .stn_addr(stn_addr)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_req) req_cnt <= req_cnt + 1;
      if (mem_req && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      else if (mem_req) mem_rdata <= mem[mem_addr[9:2]];
   end

   always @(negedge clk) begin
      tx_ready = hold ? 1'b0 : (cyc % 3 != 1);
      #1;
      if (tx_valid && tx_ready) begin
         got_b.push_back(tx_data);
         got_l.push_back(tx_last);
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic read_field(output logic [2:0] f);
      reg_addr = 4'hC;
      #1;
      f = reg_rdata[22:20];
   endtask

   task automatic wait_done();
      logic [2:0] f;
      for (int i = 0; i < 5000; i++) begin
         read_field(f);
         if (f == 3'd0 || f == 3'd6) break;
         @(negedge clk);
      end
   endtask

   task automatic set_desc(input int idx, input logic [31:0] st,
                           input logic [31:0] ct, input logic [31:0] bf);
      int w;
      w = (RING_BASE + 16 * idx) >> 2;
      mem[w] = st; mem[w+1] = ct; mem[w+2] = bf; mem[w+3] = 0;
   endtask

   function automatic logic [7:0] pat(input int len, input int off, input int k);
      return 8'((len * 13 + off * 7 + k * 3 + 1) & 8'hFF);
   endfunction

   task automatic fill_buf(input int addr, input int len, input int off);
      for (int k = 0; k < len; k++)
         mem[(addr + k) >> 2][8 * ((addr + k) & 3) +: 8] = pat(len, off, k);
   endtask

   function automatic logic [31:0] wrap_of(input int idx);
      return (idx == 3) ? WRAP : 32'h0;
   endfunction

   function automatic logic [31:0] stat_of(input int idx);
      return mem[(RING_BASE + 16 * idx) >> 2];
   endfunction

   // Sends one frame at the expected ring slot and checks bytes, last flag, status
   task automatic send_one(input int len, input int off);
      int idx, bad, lbad;
      idx = exp_idx;
      fill_buf(32'h200 + off, len, off);
      set_desc(idx, OWN, FRST | LAST | wrap_of(idx) | 32'(len), 32'h200 + off);
      got_b.delete(); got_l.delete();
      reg_write(4'h4, 0);
      wait_done();
      bad = 0; lbad = 0;
      foreach (got_b[k]) if (k < len && got_b[k] != pat(len, off, k)) bad++;
      foreach (got_l[k]) if (got_l[k] != (k == len - 1)) lbad++;
      chk(got_b.size() == len && bad == 0, "R4", $sformatf("bytes len=%0d off=%0d", len, off),
          64'(got_b.size()), 64'(len));
      chk(lbad == 0, "R4", "tx_last placement", 64'(lbad), 0);
      chk(stat_of(idx) == 32'h0, "R6", "success status", 64'(stat_of(idx)), 0);
      exp_idx = (idx + 1) % 4;
   endtask

   task automatic bad_desc(input logic [31:0] ct, input string what);
      int idx;
      idx = exp_idx;
      set_desc(idx, OWN, ct | wrap_of(idx), 32'h200);
      got_b.delete();
      reg_write(4'h4, 0);
      wait_done();
      chk(got_b.size() == 0, "R7", {what, " no bytes"}, 64'(got_b.size()), 0);
      chk(stat_of(idx) == 32'h8000, "R7", {what, " status"}, 64'(stat_of(idx)), 64'h8000);
      exp_idx = (idx + 1) % 4;
   endtask

   always @(posedge clk) begin
      if (cyc > 150000 && !ended) begin
         ended = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [2:0] f;
      int rq, idx, bad;
      logic [7:0] held;
      for (int i = 0; i < 256; i++) mem[i] = 0;
      repeat (3) @(negedge clk);
      read_field(f);
      chk(!tx_valid && !mem_req && stn_addr == 0 && f == 0, "R1", "reset state",
          {tx_valid, mem_req, 3'(f)}, 0);
      rst_n = 1;
      @(negedge clk);
      read_field(f);
      chk(f == 3'd0 && !tx_valid, "R1", "after reset release", 64'(f), 0);
      hold = 0;

      reg_write(4'h8, RING_BASE);
      set_desc(0, OWN, FRST | LAST | 32'd4, 32'h200);
      rq = req_cnt;
      reg_write(4'h4, 0);
      repeat (5) @(negedge clk);
      read_field(f);
      chk(req_cnt == rq && f == 3'd0, "R3", "poll while stopped", 64'(req_cnt - rq), 0);
      chk(stat_of(0) == OWN, "R3", "descriptor untouched", 64'(stat_of(0)), 64'(OWN));

      reg_write(4'h0, 32'h2000);
      read_field(f);
      chk(f == 3'd6, "R12", "enabled idle reads suspended", 64'(f), 6);

      set_desc(0, 32'h0, FRST | LAST | 32'd4, 32'h200);
      got_b.delete();
      reg_write(4'h4, 0);
      wait_done();
      read_field(f);
      chk(got_b.size() == 0 && f == 3'd6, "R2", "unowned descriptor", 64'(got_b.size()), 0);
      chk(stat_of(0) == 32'h0, "R2", "no write-back on unowned", 64'(stat_of(0)), 0);

      // R4/R6/R10: length x alignment sweep, ring wraps every four frames
      for (int len = 1; len <= 9; len++)
         for (int off = 0; off < 4; off++)
            send_one(len, off);

      bad_desc(FRST | 32'd5, "first only");
      bad_desc(LAST | 32'd5, "last only");
      bad_desc(FRST | LAST, "zero length");

      // R8: setup buffer absorbed into station address
      for (int w = 0; w < 48; w++) mem[(32'h300 >> 2) + w] = 32'hFFFF_FFFF;
      mem[32'h300 >> 2] = 32'hFFFF_2211;
      mem[(32'h300 >> 2) + 1] = 32'hFFFF_4433;
      mem[(32'h300 >> 2) + 2] = 32'hFFFF_6655;
      idx = exp_idx;
      set_desc(idx, OWN, SETB | wrap_of(idx) | 32'd192, 32'h300);
      got_b.delete();
      reg_write(4'h4, 0);
      wait_done();
      chk(stn_addr == 48'h6655_4433_2211, "R8", "station address", stn_addr, 48'h6655_4433_2211);
      chk(got_b.size() == 0, "R8", "setup not sent", 64'(got_b.size()), 0);
      chk(stat_of(idx) == 32'h7FFF_FFFF, "R8", "setup status", 64'(stat_of(idx)), 64'h7FFFFFFF);
      exp_idx = (idx + 1) % 4;

      // R9: wrong setup length
      mem[32'h300 >> 2] = 32'hFFFF_AAAA;
      idx = exp_idx;
      set_desc(idx, OWN, SETB | wrap_of(idx) | 32'd96, 32'h300);
      reg_write(4'h4, 0);
      wait_done();
      chk(stn_addr == 48'h6655_4433_2211, "R9", "station kept", stn_addr, 48'h6655_4433_2211);
      chk(stat_of(idx) == 32'h8000, "R9", "bad setup status", 64'(stat_of(idx)), 64'h8000);
      exp_idx = (idx + 1) % 4;

      // R10: two owned descriptors handled by one poll
      idx = exp_idx;
      fill_buf(32'h200, 3, 0);
      fill_buf(32'h280, 5, 1);
      set_desc(idx, OWN, FRST | LAST | wrap_of(idx) | 32'd3, 32'h200);
      set_desc((idx + 1) % 4, OWN, FRST | LAST | wrap_of((idx + 1) % 4) | 32'd5, 32'h280);
      got_b.delete();
      reg_write(4'h4, 0);
      wait_done();
      bad = 0;
      for (int k = 0; k < 8; k++)
         if (k < got_b.size() && got_b[k] != (k < 3 ? pat(3, 0, k) : pat(5, 1, k - 3))) bad++;
      chk(got_b.size() == 8 && bad == 0, "R10", "back-to-back frames", 64'(got_b.size()), 8);
      chk(stat_of((idx + 1) % 4) == 0, "R10", "second status", 64'(stat_of((idx + 1) % 4)), 0);
      exp_idx = (idx + 2) % 4;

      // R5/R11/R12: stall mid-frame, stop, then restart from base
      idx = exp_idx;
      fill_buf(32'h200, 4, 2);
      set_desc(idx, OWN, FRST | LAST | wrap_of(idx) | 32'd4, 32'h200);
      set_desc((idx + 1) % 4, OWN, FRST | LAST | wrap_of((idx + 1) % 4) | 32'd2, 32'h280);
      got_b.delete();
      hold = 1;
      reg_write(4'h4, 0);
      repeat (8) @(negedge clk);
      read_field(f);
      chk(f == 3'd2, "R12", "sending state", 64'(f), 2);
      held = tx_data;
      chk(tx_valid && tx_data == pat(4, 2, 0), "R5", "byte offered", 64'(tx_data), 64'(pat(4, 2, 0)));
      reg_write(4'h0, 32'h0);
      repeat (4) @(negedge clk);
      chk(tx_valid && tx_data == held, "R5", "byte held under stall", 64'(tx_data), 64'(held));
      hold = 0;
      wait_done();
      read_field(f);
      chk(f == 3'd0 && got_b.size() == 4, "R11", "stopped after frame", 64'(f), 0);
      chk(stat_of((idx + 1) % 4) == OWN, "R11", "next descriptor untouched",
          64'(stat_of((idx + 1) % 4)), 64'(OWN));
      set_desc((idx + 1) % 4, 32'h0, 32'h0, 32'h0);
      fill_buf(32'h280, 2, 3);
      set_desc(0, OWN, FRST | LAST | 32'd2, 32'h280);
      reg_write(4'h0, 32'h2000);
      got_b.delete();
      reg_write(4'h4, 0);
      wait_done();
      chk(got_b.size() == 2 && got_b[0] == pat(2, 3, 0), "R11", "restart at ring base",
          64'(got_b.size()), 2);
      chk(stat_of(0) == 0, "R6", "restart status", 64'(stat_of(0)), 0);

      ended = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule